// File: doc/BRIEF.md
# Paged Program Counter Unit

This block generates the instruction address for a small 8-bit core whose 13-bit program space is divided into eight pages of 1K words. Each cycle it accepts one decoded control operation. The operation is a sequential step, a direct jump, a subroutine call, a return, or one of three computed writes driven by the accumulator. The block then produces the next program address. A call places its return address on an internal eight-level return stack, and a return takes the address back from that stack.

A jump or a call delivers only the ten in-page address bits. The three page bits come from the page-select field of the status register, and only certain operations reload them. The computed writes touch only the low byte of the PC. Two of them clear bits 9:8, and the table-read form keeps those bits and keeps the page as well. The return stack is a ring. When it is full, a further push overwrites the oldest entry. When it is empty, a pop continues around the ring. Each of these events raises a one-cycle error flag.

The operation input is qualified by `op_valid`. The block accepts an operation on every cycle that `op_valid` is high and never applies back-pressure, so it has no ready signal. On a cycle with `op_valid` low, the core is stalled: the PC and the stack hold.

Top module: `paged_pc_unit`

## Requirements
- R1: After reset the PC is 0x0000 and `stk_err` is 0. The stack is empty, so the first return after reset is flagged as an underflow.
- R2: With `op_valid` high and `op_code` 0 (sequential step), the PC becomes PC+1 on the next cycle and wraps from 0x1FFF to 0x0000.
- R3: With `op_valid` low, the PC and the return stack keep their values whatever the other inputs are.
- R4: `op_code` 1 (jump) loads the PC with {`page_sel`, `jmp_target`}.
- R5: `op_code` 2 (call) loads the PC as a jump does and pushes PC+1 (13 bits, wrapping). `op_code` 3 (return) loads the PC from the most recent pushed entry and removes that entry, in last-in first-out order.
- R6: `op_code` 4 (move accumulator to PC) loads the PC with {`page_sel`, 2'b00, `acc`}.
- R7: `op_code` 5 (add accumulator to PC) loads the PC with {`page_sel`, 2'b00, (PC[7:0]+`acc`) mod 256}. No carry reaches bit 8.
- R8: `op_code` 6 (table read) loads the PC with {PC[12:8], (PC[7:0]+`acc`) mod 256}. The page bits and bits 9:8 are kept and `page_sel` is ignored.
- R9: A call while eight entries are held overwrites the oldest entry, and the stack still holds eight entries afterwards. `stk_err` is 1 on the cycle after that call and 0 on the cycle after any call or return that does not overflow or underflow.
- R10: A return while the stack is empty still moves the ring pointer back one slot and loads the PC from that slot. `stk_err` is 1 on the cycle after it.
- R11: `op_code` 7 is reserved and behaves exactly as the sequential step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Decoded operation (0 step, 1 jump, 2 call, 3 return, 4 move, 5 add, 6 table, 7 reserved) |
| jmp_target | input | 10 | In-page target for jump and call |
| acc | input | 8 | Accumulator value for computed writes |
| page_sel | input | 3 | Page-select field of the status register |
| pc | output | 13 | Current program address |
| stk_err | output | 1 | One-cycle pulse after a stack overflow or underflow |

## Verification
The bench builds the block with its default parameters: a 13-bit PC, a 10-bit page offset, an 8-bit accumulator and eight stack levels. At these sizes a single jump to offset 0x3FF of page 7 reaches the wrap from 0x1FFF. Nine calls fill the ring and overwrite its oldest entry, and a further chain of returns drains it past empty. Random operation mixes with random stalls check that the computed writes keep or clear the right bits on every page.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RETN = 3'd3,
    OP_MOVA = 3'd4,
    OP_ADDA = 3'd5,
    OP_TABL = 3'd6,
    OP_RSVD = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
  import pcu_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int OFS_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              op_valid,
  input  pc_op_e            op,
  input  logic [PC_W-1:0]   pc_cur,
  input  logic [OFS_W-1:0]  target,
  input  logic [BYTE_W-1:0] acc,
  input  logic [PC_W-OFS_W-1:0] page_sel,
  input  logic [PC_W-1:0]   tos,
  output logic [PC_W-1:0]   pc_next
);
  localparam int PAGE_W = PC_W - OFS_W;
  localparam int MID_W  = OFS_W - BYTE_W;

  logic [BYTE_W-1:0] low_sum;
  logic [PC_W-1:0]   seq_addr;

  // Low-byte sum wraps inside the byte; no carry into the mid bits.
  assign low_sum  = pc_cur[BYTE_W-1:0] + acc;
  assign seq_addr = pc_cur + {{(PC_W-1){1'b0}}, 1'b1};

  always_comb begin
    pc_next = pc_cur;
    if (op_valid) begin
      unique case (op)
        OP_JUMP, OP_CALL: pc_next = {page_sel, target};
        OP_RETN:          pc_next = tos;
        OP_MOVA:          pc_next = {page_sel, {MID_W{1'b0}}, acc};
        OP_ADDA:          pc_next = {page_sel, {MID_W{1'b0}}, low_sum};
        OP_TABL:          pc_next = {pc_cur[PC_W-1:BYTE_W], low_sum};
        default:          pc_next = seq_addr;
      endcase
    end
  end

  initial begin
    a_r8_widths: assert (PAGE_W > 0 && MID_W >= 0);
  end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int AW    = 13,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] tos,
  output logic          err
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FIL_W = $clog2(DEPTH + 1);
  localparam logic [FIL_W-1:0] FULL = FIL_W'(DEPTH);

  logic [AW-1:0]    slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [FIL_W-1:0] fill;

  assign rd_ptr = wr_ptr - {{(PTR_W-1){1'b0}}, 1'b1};
  assign tos    = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
      err    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      err <= 1'b0;
      if (push) begin
        slot[wr_ptr] <= push_addr;
        wr_ptr       <= wr_ptr + {{(PTR_W-1){1'b0}}, 1'b1};
        if (fill == FULL) err  <= 1'b1;
        else              fill <= fill + {{(FIL_W-1){1'b0}}, 1'b1};
      end else if (pop) begin
        wr_ptr <= rd_ptr;
        if (fill == '0) err  <= 1'b1;
        else            fill <= fill - {{(FIL_W-1){1'b0}}, 1'b1};
      end
    end
  end

  initial begin
    a_r9_depth_pow2: assert ((1 << PTR_W) == DEPTH);
  end

  a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);

  a_r9_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    push && (fill == FULL) |=> err);

  a_r10_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !push && pop && (fill == '0) |=> err);

  a_r9_quiet_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !push && !pop |=> !err);

  a_r5_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> tos == $past(push_addr));
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
  import pcu_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int OFS_W  = 10,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [2:0]            op_code,
  input  logic [OFS_W-1:0]      jmp_target,
  input  logic [BYTE_W-1:0]     acc,
  input  logic [PC_W-OFS_W-1:0] page_sel,
  output logic [PC_W-1:0]       pc,
  output logic                  stk_err
);
  localparam int PAGE_W = PC_W - OFS_W;

  pc_op_e          op;
  logic            do_push;
  logic            do_pop;
  logic [PC_W-1:0] tos;
  logic [PC_W-1:0] pc_next;
  logic [PC_W-1:0] ret_addr;

  assign op       = pc_op_e'(op_code);
  assign do_push  = op_valid && (op == OP_CALL);
  assign do_pop   = op_valid && (op == OP_RETN);
  assign ret_addr = pc + {{(PC_W-1){1'b0}}, 1'b1};

  pcu_next_addr #(.PC_W(PC_W), .OFS_W(OFS_W), .BYTE_W(BYTE_W)) u_next (
    .op_valid (op_valid),
    .op       (op),
    .pc_cur   (pc),
    .target   (jmp_target),
    .acc      (acc),
    .page_sel (page_sel),
    .tos      (tos),
    .pc_next  (pc_next)
  );

  pcu_ret_stack #(.AW(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_push),
    .pop       (do_pop),
    .push_addr (ret_addr),
    .tos       (tos),
    .err       (stk_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 3'd0) |=> pc == $past(pc) + 1'b1);

  a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(pc));

  a_r4_jump: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 3'd1) |=> pc == {$past(page_sel), $past(jmp_target)});

  a_r6_move: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 3'd4) |=>
      pc[BYTE_W-1:0] == $past(acc) && pc[PC_W-1:OFS_W] == $past(page_sel)
      && pc[OFS_W-1:BYTE_W] == '0);

  a_r8_table_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 3'd6) |=> pc[PC_W-1:BYTE_W] == $past(pc[PC_W-1:BYTE_W]));

  a_r7_add_clears_mid: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 3'd5) |=> pc[OFS_W-1:BYTE_W] == '0);

  initial begin
    a_r1_page_width: assert (PAGE_W >= 1);
  end
endmodule

// File: tb/paged_pc_unit_test.sv
`timescale 1ns/1ps
module paged_pc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [9:0]  jmp_target;
  logic [7:0]  acc;
  logic [2:0]  page_sel;
  logic [12:0] pc;
  logic        stk_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [12:0] m_pc;
  logic [12:0] m_stk [8];
  logic [2:0]  m_ptr;
  int          m_fill;
  logic        m_err;

  always #10 clk = ~clk;

  paged_pc_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .jmp_target(jmp_target), .acc(acc), .page_sel(page_sel),
    .pc(pc), .stk_err(stk_err)
  );

  function automatic string tag_of(logic v, logic [2:0] o);
    if (!v) return "R3";
    case (o)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = '0; m_ptr = '0; m_fill = 0; m_err = 1'b0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
  endtask

  task automatic model_step(logic v, logic [2:0] o, logic [9:0] t, logic [7:0] a, logic [2:0] p);
    logic [12:0] nxt;
    logic [7:0]  lsum;
    m_err = 1'b0;
    nxt = m_pc;
    lsum = m_pc[7:0] + a;
    if (v) begin
      case (o)
        3'd1: nxt = {p, t};
        3'd2: begin
          nxt = {p, t};
          m_stk[m_ptr] = m_pc + 13'd1;
          m_ptr = m_ptr + 3'd1;
          if (m_fill == 8) m_err = 1'b1; else m_fill++;
        end
        3'd3: begin
          m_ptr = m_ptr - 3'd1;
          nxt = m_stk[m_ptr];
          if (m_fill == 0) m_err = 1'b1; else m_fill--;
        end
        3'd4: nxt = {p, 2'b00, a};
        3'd5: nxt = {p, 2'b00, lsum};
        3'd6: nxt = {m_pc[12:8], lsum};
        default: nxt = m_pc + 13'd1;
      endcase
    end
    m_pc = nxt;
  endtask

  task automatic step(logic v, logic [2:0] o, logic [9:0] t, logic [7:0] a, logic [2:0] p, string tag);
    op_valid = v; op_code = o; jmp_target = t; acc = a; page_sel = p;
    model_step(v, o, t, a, p);
    @(posedge clk);
    @(negedge clk);
    chk(tag, {19'd0, pc}, {19'd0, m_pc});
    chk({tag, "/R9"}, {31'd0, stk_err}, {31'd0, m_err});
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; jmp_target = '0; acc = '0; page_sel = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", {19'd0, pc}, 32'd0);
    chk("R1", {31'd0, stk_err}, 32'd0);

    // R1 / R10: return straight after reset underflows
    step(1, 3'd3, 10'h000, 8'h00, 3'd0, "R10");
    // reset again to a clean state
    rst_n = 1'b0; model_reset();
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk("R1", {19'd0, pc}, 32'd0);

    // R2: wrap from 0x1FFF
    step(1, 3'd1, 10'h3FF, 8'h00, 3'd7, "R4");
    chk("R2", {19'd0, pc}, 32'h1FFF);
    step(1, 3'd0, 10'h000, 8'h00, 3'd0, "R2");
    chk("R2", {19'd0, pc}, 32'h0000);

    // R3: stall with busy inputs
    step(0, 3'd1, 10'h155, 8'hAA, 3'd5, "R3");
    step(0, 3'd2, 10'h0AA, 8'h55, 3'd2, "R3");

    // R11: reserved op
    step(1, 3'd7, 10'h123, 8'h44, 3'd6, "R11");

    // R6 / R7 / R8 directed
    step(1, 3'd1, 10'h3F0, 8'h00, 3'd5, "R4");
    step(1, 3'd6, 10'h000, 8'h20, 3'd1, "R8");
    chk("R8", {19'd0, pc}, 32'h1710);
    step(1, 3'd5, 10'h000, 8'hF5, 3'd2, "R7");
    chk("R7", {19'd0, pc}, 32'h0805);
    step(1, 3'd4, 10'h000, 8'h9C, 3'd3, "R6");
    chk("R6", {19'd0, pc}, 32'h0C9C);

    // R9: nine calls, then ten returns (R5 order, R10 underflow)
    for (int i = 0; i < 9; i++)
      step(1, 3'd2, 10'(i * 16 + 3), 8'h00, 3'(i), (i == 8) ? "R9" : "R5");
    chk("R9", {31'd0, stk_err}, 32'd1);
    for (int i = 0; i < 10; i++)
      step(1, 3'd3, 10'h000, 8'h00, 3'd0, (i >= 8) ? "R10" : "R5");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic v;
      logic [2:0] o;
      v = ($urandom % 8) != 0;
      o = 3'($urandom % 8);
      step(v, o, 10'($urandom), 8'($urandom), 3'($urandom), tag_of(v, o));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule